// File: doc/BRIEF.md
# Four-Channel Memory Copy DMA Engine

This block moves blocks of data from one memory address range to another without processor involvement. Software programs each of four channels through a small bank of 32-bit registers: an element count, 64-bit source and destination addresses, and a control word. Writing the control word with its enable bit set both stores the word and launches the copy.

Each element is 1, 2, 4 or 8 bytes wide. Source and destination stepping are enabled separately, so the same engine can do plain copies, fills from one fixed location, and drains into one fixed location. The engine moves one element at a time. It reads the element through a single-beat memory master port and then writes it back out through the same port. One channel runs at a time. Channels that are waiting are served lowest index first. A shared status register reports per-channel busy and completion flags. The completion flags are cleared by writing ones to them.

Top module: `quad_copy_dma`

## Requirements
- R1: After reset every channel register and the status register read as zero.
- R2: Channel c owns offsets c*8 to c*8+7, in this order: control, count, source high, source low, destination high, destination low, list-pointer high, list-pointer low. Writing one 32-bit half of a 64-bit address leaves the other half unchanged.
- R3: The list-pointer registers are plain read/write storage and cause no memory access.
- R4: A control write with bit 31 set, to an idle channel whose count (low 16 bits of the count register) is nonzero, starts a copy of that many elements. Each element is read from memory in little-endian byte order and written unchanged, in the low bytes of the write data.
- R5: Control bits 26:25 give the element width as 1 << field bytes. The memSize output carries the field during every access.
- R6: Control bit 24 makes the destination address step by the element width after each element, and bit 23 does the same for the source. When either bit is clear, that address stays fixed.
- R7: A start with a count of zero makes no memory access and sets neither busy nor done.
- R8: Status bits 3:0 are per-channel done flags, set when a channel's last element has been written. A write to offset 0x20 clears every done flag whose bit is 1 in the written value and keeps the others.
- R9: Status bits 7:4 are per-channel busy flags (waiting or running). A control write to a busy channel stores the new value but does not restart or extend the transfer.
- R10: Each element is one read accepted by memReady, then one write accepted by memReady. A request and its address are held until accepted, and a read and a write are never requested together.
- R11: When several channels are waiting, the lowest-numbered one is served next.
- R12: Offsets 0x21 to 0x3F read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 6 | Register offset for read and write |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr (combinational) |
| memRd | output | 1 | Memory read request |
| memWr | output | 1 | Memory write request |
| memAddr | output | 64 | Byte address of the current access |
| memSize | output | 2 | Element width code of the current access |
| memWdata | output | 64 | Write data, element in the low bytes |
| memRdata | input | 64 | Read data, element in the low bytes |
| memReady | input | 1 | Accepts the current request this cycle |

## Verification
The copy path is tried with both addresses stepping, at each of the four widths, so that stride and byte-lane masking errors show up as wrong addresses or stray upper bytes. Fill runs (fixed source) and drain runs (fixed destination) show whether each increment enable acts on its own address. The memory stalls at irregular times, so held requests are exercised. One channel's upper address halves are nonzero, which exposes any truncation of the 64-bit addresses. A long running channel with two more channels started behind it in reverse order shows the service order. A control rewrite during a run, and a zero-count start, each show whether they produce any memory traffic beyond what is expected.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  // Register slot index inside a channel's eight-word window
  localparam logic [2:0] SLOT_CTL    = 3'd0;
  localparam logic [2:0] SLOT_CNT    = 3'd1;
  localparam logic [2:0] SLOT_SRC_HI = 3'd2;
  localparam logic [2:0] SLOT_SRC_LO = 3'd3;
  localparam logic [2:0] SLOT_DST_HI = 3'd4;
  localparam logic [2:0] SLOT_DST_LO = 3'd5;
  localparam logic [2:0] SLOT_LST_HI = 3'd6;
  localparam logic [2:0] SLOT_LST_LO = 3'd7;

  // Control word fields
  localparam int CTL_EN     = 31;
  localparam int CTL_WID_HI = 26;
  localparam int CTL_WID_LO = 25;
  localparam int CTL_DINC   = 24;
  localparam int CTL_SINC   = 23;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } moveState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;        // copy the selected channel's setup into working registers
    logic capture;     // latch the element returned by memory
    logic step;        // advance addresses and remaining count
    logic writePhase;  // present destination address instead of source
  } moveStrobe_t;

endpackage

// File: rtl/xfer_datapath.sv
module xfer_datapath
  import xfer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 16,
  parameter int MADDR_W = 64,
  parameter int MDATA_W = 64,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  input  logic [31:0]        statusWord,
  output logic               stsWr,
  input  moveStrobe_t        strobe,
  input  logic [CH_W-1:0]    chanSel,
  output logic [NUM_CH-1:0]  startReq,
  output logic               lastElem,
  output logic [MADDR_W-1:0] memAddr,
  output logic [1:0]         memSize,
  output logic [MDATA_W-1:0] memWdata,
  input  logic [MDATA_W-1:0] memRdata
);

  localparam logic [ADDR_W-1:0] STATUS_OFF = ADDR_W'(NUM_CH * 8);

  logic [31:0]        ctlReg [NUM_CH];
  logic [31:0]        cntReg [NUM_CH];
  logic [MADDR_W-1:0] srcReg [NUM_CH];
  logic [MADDR_W-1:0] dstReg [NUM_CH];
  logic [MADDR_W-1:0] lstReg [NUM_CH];

  logic [2:0]       slot;
  logic [CH_W-1:0]  chanIdx;
  logic             inBank;

  assign slot    = regAddr[2:0];
  assign chanIdx = CH_W'(regAddr[ADDR_W-1:3]);
  assign inBank  = regAddr < STATUS_OFF;
  assign stsWr   = regWr && (regAddr == STATUS_OFF);

  // Register bank
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) begin
        ctlReg[c] <= '0;
        cntReg[c] <= '0;
        srcReg[c] <= '0;
        dstReg[c] <= '0;
        lstReg[c] <= '0;
      end
    end else if (regWr && inBank) begin
      case (slot)
        SLOT_CTL:    ctlReg[chanIdx] <= regWdata;
        SLOT_CNT:    cntReg[chanIdx] <= regWdata;
        SLOT_SRC_HI: srcReg[chanIdx][MADDR_W-1:32] <= regWdata[MADDR_W-33:0];
        SLOT_SRC_LO: srcReg[chanIdx][31:0] <= regWdata;
        SLOT_DST_HI: dstReg[chanIdx][MADDR_W-1:32] <= regWdata[MADDR_W-33:0];
        SLOT_DST_LO: dstReg[chanIdx][31:0] <= regWdata;
        SLOT_LST_HI: lstReg[chanIdx][MADDR_W-1:32] <= regWdata[MADDR_W-33:0];
        default:     lstReg[chanIdx][31:0] <= regWdata;
      endcase
    end
  end

  // Start requests: enabled control write with a nonzero element count
  for (genvar c = 0; c < NUM_CH; c++) begin : g_start
    assign startReq[c] = regWr && inBank && (chanIdx == CH_W'(c)) &&
                         (slot == SLOT_CTL) && regWdata[CTL_EN] &&
                         (cntReg[c][CNT_W-1:0] != '0);
  end

  // Read mux
  always_comb begin
    regRdata = '0;
    if (inBank) begin
      case (slot)
        SLOT_CTL:    regRdata = ctlReg[chanIdx];
        SLOT_CNT:    regRdata = cntReg[chanIdx];
        SLOT_SRC_HI: regRdata = 32'(srcReg[chanIdx][MADDR_W-1:32]);
        SLOT_SRC_LO: regRdata = srcReg[chanIdx][31:0];
        SLOT_DST_HI: regRdata = 32'(dstReg[chanIdx][MADDR_W-1:32]);
        SLOT_DST_LO: regRdata = dstReg[chanIdx][31:0];
        SLOT_LST_HI: regRdata = 32'(lstReg[chanIdx][MADDR_W-1:32]);
        default:     regRdata = lstReg[chanIdx][31:0];
      endcase
    end else if (regAddr == STATUS_OFF) begin
      regRdata = statusWord;
    end
  end

  // Working copy of the running transfer
  logic [MADDR_W-1:0] srcPtr, dstPtr;
  logic [CNT_W-1:0]   remain;
  logic [1:0]         widCode;
  logic               srcStep, dstStep;
  logic [MDATA_W-1:0] elemBuf, laneMask;
  logic [MADDR_W-1:0] stride;

  assign stride = MADDR_W'(1) << widCode;

  always_comb begin
    case (widCode)
      2'd0:    laneMask = MDATA_W'(8'hFF);
      2'd1:    laneMask = MDATA_W'(16'hFFFF);
      2'd2:    laneMask = MDATA_W'(32'hFFFF_FFFF);
      default: laneMask = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcPtr  <= '0;
      dstPtr  <= '0;
      remain  <= '0;
      widCode <= '0;
      srcStep <= 1'b0;
      dstStep <= 1'b0;
      elemBuf <= '0;
    end else begin
      if (strobe.load) begin
        srcPtr  <= srcReg[chanSel];
        dstPtr  <= dstReg[chanSel];
        remain  <= cntReg[chanSel][CNT_W-1:0];
        widCode <= ctlReg[chanSel][CTL_WID_HI:CTL_WID_LO];
        srcStep <= ctlReg[chanSel][CTL_SINC];
        dstStep <= ctlReg[chanSel][CTL_DINC];
      end
      if (strobe.capture) elemBuf <= memRdata & laneMask;
      if (strobe.step) begin
        if (srcStep) srcPtr <= srcPtr + stride;
        if (dstStep) dstPtr <= dstPtr + stride;
        remain <= remain - CNT_W'(1);
      end
    end
  end

  assign lastElem = (remain == CNT_W'(1));
  assign memAddr  = strobe.writePhase ? dstPtr : srcPtr;
  assign memSize  = widCode;
  assign memWdata = elemBuf;

endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] startReq,
  input  logic              lastElem,
  input  logic              stsWr,
  input  logic [NUM_CH-1:0] stsClr,
  input  logic              memReady,
  output moveStrobe_t       strobe,
  output logic [CH_W-1:0]   chanSel,
  output logic              memRd,
  output logic              memWr,
  output logic [31:0]       statusWord
);

  moveState_t        state;
  logic [CH_W-1:0]   curChan, pickIdx;
  logic              found;
  logic [NUM_CH-1:0] pending, doneFlag, busy, activeMask;
  logic [NUM_CH-1:0] pendNext, doneNext, pickMask, finishMask;

  // Lowest-numbered waiting channel wins
  always_comb begin
    pickIdx = '0;
    found   = 1'b0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (pending[c]) begin
        pickIdx = CH_W'(c);
        found   = 1'b1;
      end
    end
  end

  assign activeMask = (state != ST_IDLE) ? (NUM_CH'(1) << curChan) : '0;
  assign busy       = pending | activeMask;

  always_comb begin
    strobe  = '0;
    memRd   = 1'b0;
    memWr   = 1'b0;
    chanSel = (state == ST_IDLE) ? pickIdx : curChan;
    case (state)
      ST_IDLE:  strobe.load = found;
      ST_READ: begin
        memRd          = 1'b1;
        strobe.capture = memReady;
      end
      ST_WRITE: begin
        memWr             = 1'b1;
        strobe.writePhase = 1'b1;
        strobe.step       = memReady;
      end
      default: ;
    endcase
  end

  assign pickMask   = (state == ST_IDLE && found) ? (NUM_CH'(1) << pickIdx) : '0;
  assign finishMask = (state == ST_WRITE && memReady && lastElem) ?
                      (NUM_CH'(1) << curChan) : '0;

  always_comb begin
    pendNext = (pending & ~pickMask) | (startReq & ~busy);
    doneNext = (doneFlag & ~(stsWr ? stsClr : '0)) | finishMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      curChan  <= '0;
      pending  <= '0;
      doneFlag <= '0;
    end else begin
      pending  <= pendNext;
      doneFlag <= doneNext;
      case (state)
        ST_IDLE: if (found) begin
          curChan <= pickIdx;
          state   <= ST_READ;
        end
        ST_READ:  if (memReady) state <= ST_WRITE;
        ST_WRITE: if (memReady) state <= lastElem ? ST_IDLE : ST_READ;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[NUM_CH-1:0]        = doneFlag;
    statusWord[2*NUM_CH-1:NUM_CH] = busy;
  end

endmodule

// File: rtl/quad_copy_dma.sv
module quad_copy_dma
  import xfer_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int ADDR_W  = 6,
  parameter int CNT_W   = 16,
  parameter int MADDR_W = 64,
  parameter int MDATA_W = 64,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  output logic               memRd,
  output logic               memWr,
  output logic [MADDR_W-1:0] memAddr,
  output logic [1:0]         memSize,
  output logic [MDATA_W-1:0] memWdata,
  input  logic [MDATA_W-1:0] memRdata,
  input  logic               memReady
);

  moveStrobe_t       strobe;
  logic [CH_W-1:0]   chanSel;
  logic [NUM_CH-1:0] startReq;
  logic              lastElem, stsWr;
  logic [31:0]       statusWord;

  xfer_datapath #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .MADDR_W(MADDR_W), .MDATA_W(MDATA_W)
  ) u_path (
    .clk(clk), .rstN(rstN),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .statusWord(statusWord), .stsWr(stsWr),
    .strobe(strobe), .chanSel(chanSel),
    .startReq(startReq), .lastElem(lastElem),
    .memAddr(memAddr), .memSize(memSize), .memWdata(memWdata), .memRdata(memRdata)
  );

  xfer_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .startReq(startReq), .lastElem(lastElem),
    .stsWr(stsWr), .stsClr(regWdata[NUM_CH-1:0]),
    .memReady(memReady),
    .strobe(strobe), .chanSel(chanSel),
    .memRd(memRd), .memWr(memWr),
    .statusWord(statusWord)
  );

endmodule

// File: rtl/quad_copy_dma_chk.sv
module quad_copy_dma_chk #(
  parameter int MADDR_W = 64
) (
  input logic               clk,
  input logic               rstN,
  input logic               memRd,
  input logic               memWr,
  input logic               memReady,
  input logic [MADDR_W-1:0] memAddr
);

  // R10: read and write never requested together
  p_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  // R10: an unaccepted read stays requested at the same address
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    memRd && !memReady |=> memRd && $stable(memAddr));

  // R10: an unaccepted write stays requested at the same address
  p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    memWr && !memReady |=> memWr && $stable(memAddr));

  // R10: a write phase only begins right after an accepted read
  p_rd_then_wr_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWr) |-> $past(memRd && memReady));

endmodule

bind quad_copy_dma quad_copy_dma_chk #(.MADDR_W(MADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .memRd(memRd), .memWr(memWr),
  .memReady(memReady), .memAddr(memAddr)
);

// File: tb/quad_copy_dma_test.sv
module quad_copy_dma_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        memRd, memWr, memReady;
  logic [63:0] memAddr, memWdata, memRdata;
  logic [1:0]  memSize;

  always #4 clk = ~clk;  // 125 MHz

  quad_copy_dma uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .memRd(memRd), .memWr(memWr), .memAddr(memAddr), .memSize(memSize),
    .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady)
  );

  // Memory model: 4 KiB byte array, addressed by the low 12 address bits
  logic [7:0] mem [0:4095];
  logic [2:0] stallCnt = '0;
  int rdCount = 0;
  int wrCount = 0;
  int checks = 0;
  int fails = 0;

  assign memReady = (memRd | memWr) & (stallCnt != 3'd5) & (stallCnt != 3'd2);

  always_comb begin
    for (int k = 0; k < 8; k++)
      memRdata[8*k +: 8] = mem[12'(memAddr[11:0] + 12'(k))];
  end

  always @(posedge clk) begin
    stallCnt <= stallCnt + 3'd1;
    if (rstN && memWr && memReady)
      for (int k = 0; k < (1 << memSize); k++)
        mem[12'(memAddr[11:0] + 12'(k))] <= memWdata[8*k +: 8];
  end

  typedef struct {
    logic [63:0] addr;
    logic [63:0] data;
    logic [1:0]  sz;
  } item_t;
  item_t expQ[$];

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: compares every accepted memory write against the scoreboard
  always @(negedge clk) begin
    if (rstN && memRd && memReady) rdCount++;
    if (rstN && memWr && memReady) begin
      wrCount++;
      if (expQ.size() == 0) begin
        check(1'b0, "R7/R9 unexpected write", memAddr, 64'h0);
      end else begin
        item_t e;
        e = expQ.pop_front();
        check(memAddr == e.addr, "R4/R6/R11 write address", memAddr, e.addr);
        check(memWdata == e.data, "R4/R5 write data", memWdata, e.data);
        check(memSize == e.sz, "R5 access size", 64'(memSize), 64'(e.sz));
      end
    end
  end

  task automatic regWrite(int addr, logic [31:0] data);
    @(negedge clk);
    regWr = 1'b1; regAddr = 6'(addr); regWdata = data;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(int addr, output logic [31:0] data);
    @(negedge clk);
    regWr = 1'b0; regAddr = 6'(addr);
    #1 data = regRdata;
  endtask

  task automatic setupChan(int ch, int cnt, logic [63:0] src, logic [63:0] dst);
    regWrite(ch*8 + 1, 32'(cnt));
    regWrite(ch*8 + 2, src[63:32]);
    regWrite(ch*8 + 3, src[31:0]);
    regWrite(ch*8 + 4, dst[63:32]);
    regWrite(ch*8 + 5, dst[31:0]);
  endtask

  // Driver: pushes the writes the requirements predict for one transfer
  task automatic pushExpect(logic [1:0] wc, bit sInc, bit dInc, int cnt,
                            logic [63:0] src, logic [63:0] dst);
    int w;
    w = 1 << wc;
    for (int i = 0; i < cnt; i++) begin
      item_t e;
      logic [63:0] sa;
      sa = src + (sInc ? 64'(i*w) : 64'h0);
      e.addr = dst + (dInc ? 64'(i*w) : 64'h0);
      e.sz = wc;
      e.data = '0;
      for (int k = 0; k < w; k++)
        e.data[8*k +: 8] = mem[12'(sa[11:0] + 12'(k))];
      expQ.push_back(e);
    end
  endtask

  function automatic logic [31:0] ctlWord(logic [1:0] wc, bit sInc, bit dInc);
    return {1'b1, 4'b0, wc, dInc, sInc, 23'b0};
  endfunction

  task automatic waitIdle();
    logic [31:0] s;
    int n;
    n = 0;
    do begin
      regRead(32, s);
      n++;
    end while (s[7:4] != 4'h0 && n < 5000);
    check(s[7:4] == 4'h0, "R9 busy clears", 64'(s[7:4]), 64'h0);
  endtask

  task automatic runOne(int ch, logic [1:0] wc, bit sInc, bit dInc, int cnt,
                        logic [63:0] src, logic [63:0] dst);
    logic [31:0] s;
    setupChan(ch, cnt, src, dst);
    pushExpect(wc, sInc, dInc, cnt, src, dst);
    regWrite(ch*8, ctlWord(wc, sInc, dInc));
    waitIdle();
    check(expQ.size() == 0, "R4 all elements written", 64'(expQ.size()), 64'h0);
    regRead(32, s);
    check(s[ch] == 1'b1, "R8 done flag set", 64'(s[ch]), 64'h1);
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] s0;
    int rd0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: everything reads zero after reset
    for (int a = 0; a <= 32; a++) begin
      regRead(a, v);
      check(v == 32'h0, "R1 reset value", 64'(v), 64'h0);
    end

    // R2: independent 64-bit halves
    regWrite(8 + 2, 32'hDEAD_BEEF);
    regWrite(8 + 3, 32'h1234_5678);
    regRead(8 + 2, v); check(v == 32'hDEAD_BEEF, "R2 source high", 64'(v), 64'hDEADBEEF);
    regRead(8 + 3, v); check(v == 32'h1234_5678, "R2 source low", 64'(v), 64'h12345678);
    regWrite(8 + 2, 32'hCAFE_0000);
    regRead(8 + 3, v); check(v == 32'h1234_5678, "R2 low kept", 64'(v), 64'h12345678);
    regWrite(24 + 5, 32'h0000_0ABC);
    regRead(24 + 4, v); check(v == 32'h0, "R2 dest high kept", 64'(v), 64'h0);

    // R3: list pointer storage only
    regWrite(16 + 6, 32'h0BAD_F00D);
    regWrite(16 + 7, 32'h5555_AAAA);
    regRead(16 + 6, v); check(v == 32'h0BAD_F00D, "R3 list high", 64'(v), 64'h0BADF00D);
    regRead(16 + 7, v); check(v == 32'h5555_AAAA, "R3 list low", 64'(v), 64'h5555AAAA);
    repeat (4) @(negedge clk);
    check(rdCount == 0 && wrCount == 0, "R3 no memory access", 64'(rdCount + wrCount), 64'h0);

    // R4: incrementing copy, 4-byte elements
    runOne(0, 2'd2, 1'b1, 1'b1, 4, 64'h100, 64'h800);
    // R5: other widths, nonzero high address halves on channel 3
    runOne(1, 2'd0, 1'b1, 1'b1, 5, 64'h140, 64'h840);
    runOne(2, 2'd1, 1'b1, 1'b1, 3, 64'h160, 64'h880);
    runOne(3, 2'd3, 1'b1, 1'b1, 2, 64'h0000_0005_0000_0180, 64'h0000_0001_0000_08C0);
    // R6: fill (fixed source) and drain (fixed destination)
    runOne(0, 2'd2, 1'b0, 1'b1, 3, 64'h1C0, 64'h900);
    runOne(1, 2'd1, 1'b1, 1'b0, 4, 64'h1E0, 64'h940);

    // R8: write-one-to-clear done flags
    regRead(32, v); check(v[3:0] == 4'hF, "R8 all done", 64'(v[3:0]), 64'hF);
    regWrite(32, 32'h5);
    regRead(32, v); check(v[3:0] == 4'hA, "R8 partial clear", 64'(v[3:0]), 64'hA);
    regWrite(32, 32'hF);
    regRead(32, v); check(v == 32'h0, "R8 full clear", 64'(v), 64'h0);

    // R7: zero count start
    rd0 = rdCount;
    setupChan(2, 0, 64'h300, 64'hB00);
    regWrite(16, ctlWord(2'd0, 1'b1, 1'b1));
    regRead(32, v); check(v == 32'h0, "R7 no busy or done", 64'(v), 64'h0);
    repeat (20) @(negedge clk);
    regRead(32, v); check(v == 32'h0, "R7 still idle", 64'(v), 64'h0);
    check(rdCount == rd0, "R7 no reads", 64'(rdCount), 64'(rd0));

    // R9: busy flag, control rewrite during a run
    setupChan(0, 10, 64'h200, 64'hA00);
    pushExpect(2'd0, 1'b1, 1'b1, 10, 64'h200, 64'hA00);
    regWrite(0, ctlWord(2'd0, 1'b1, 1'b1));
    regRead(32, v); check(v[4] == 1'b1, "R9 busy while running", 64'(v[4]), 64'h1);
    regWrite(0, ctlWord(2'd1, 1'b1, 1'b0));
    regRead(0, v); check(v == ctlWord(2'd1, 1'b1, 1'b0), "R9 rewrite stored", 64'(v),
                         64'(ctlWord(2'd1, 1'b1, 1'b0)));
    waitIdle();
    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "R9 run completed once", 64'(expQ.size()), 64'h0);
    regRead(32, v); check(v[0] == 1'b1, "R9 done after run", 64'(v[0]), 64'h1);

    // R11: channels 2 and 1 wait behind channel 3; channel 1 goes first
    regWrite(32, 32'hF);
    setupChan(3, 8, 64'h400, 64'hC00);
    setupChan(2, 3, 64'h440, 64'hC80);
    setupChan(1, 3, 64'h460, 64'hCC0);
    pushExpect(2'd0, 1'b1, 1'b1, 8, 64'h400, 64'hC00);
    pushExpect(2'd0, 1'b1, 1'b1, 3, 64'h460, 64'hCC0);
    pushExpect(2'd0, 1'b1, 1'b1, 3, 64'h440, 64'hC80);
    regWrite(24, ctlWord(2'd0, 1'b1, 1'b1));
    regWrite(16, ctlWord(2'd0, 1'b1, 1'b1));
    regWrite(8,  ctlWord(2'd0, 1'b1, 1'b1));
    regRead(32, v); check(v[7:4] == 4'hE, "R11 three busy", 64'(v[7:4]), 64'hE);
    waitIdle();
    check(expQ.size() == 0, "R11 all served", 64'(expQ.size()), 64'h0);
    regRead(32, v); check(v[3:0] == 4'hE, "R11 done flags", 64'(v[3:0]), 64'hE);

    // R12: unmapped offsets
    regRead(32, s0);
    regWrite(48, 32'hFFFF_FFFF);
    regRead(48, v); check(v == 32'h0, "R12 unmapped read", 64'(v), 64'h0);
    regRead(33, v); check(v == 32'h0, "R12 offset 0x21", 64'(v), 64'h0);
    regRead(63, v); check(v == 32'h0, "R12 offset 0x3F", 64'(v), 64'h0);
    regRead(32, v); check(v == s0, "R12 status untouched", 64'(v), 64'(s0));

    // R10: one read per written element
    check(rdCount == wrCount, "R10 reads match writes", 64'(rdCount), 64'(wrCount));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule